// File: doc/BRIEF.md
# Instruction Register Footprint Extractor

This block sits beside a 64-bit integer pipeline and describes the effects of one 32-bit instruction word. It decodes the base integer, atomic and CSR-access instruction groups. For each word presented with its PC and a valid strobe, it reports three sets of general registers: those the instruction reads, those it writes, and those that form a memory address. It also reports whether a CSR is read or written, which CSR is involved, a coarse class for the instruction, and the set of addresses that could follow it.

A memory-ordering analysis uses these outputs to build dependency edges between instructions. The block does not execute anything. Words it does not recognise come out with empty register sets and the simple class.

Top module: `reg_footprint_unit`

## Requirements
- R1: Register x0 never appears in the read, write or address mask, even when an operand field names it. Bit i of each 32-bit mask stands for register xi.
- R2: Reset clears out_valid and every result to zero. out_valid equals in_valid from the previous cycle. While in_valid is low, all results hold their last values.
- R3: A load (opcode 0000011, funct3 not 111) and a load-reserved (opcode 0101111, funct3 010 or 011, funct5 00010, rs2 field 0) read rs1, use rs1 as the address, and write rd. Their class is 2 (memory read).
- R4: A store (opcode 0100011, funct3 000 to 011) reads rs1 and rs2, uses only rs1 as the address, writes nothing, and has class 3 (memory write).
- R5: On opcode 0101111 with funct3 010 or 011, a store-conditional (funct5 00011) reads rs1 and rs2, uses rs1 as the address, writes rd, and has class 3. An atomic read-modify-write (funct5 00000, 00001, 00100, 01000, 01100, 10000, 10100, 11000 or 11100) does the same but has class 4.
- R6: A direct jump (opcode 1101111) writes rd and reports one candidate: PC plus the sign-extended J-immediate, with the indirect flag clear. Its class is 1 (branch).
- R7: An indirect jump (opcode 1100111, funct3 000) reads rs1, writes rd, reports one candidate with the indirect flag set and npc_a zero, and has class 1.
- R8: A conditional branch (opcode 1100011, funct3 not 010/011) reads rs1 and rs2 and has class 1. It reports two candidates: npc_a is PC plus the sign-extended B-immediate and npc_b is PC+4.
- R9: A CSR access (opcode 1110011, funct3 not 000/100) sets csr_rd, presents bits 31:20 as the CSR number, and writes rd. It reads rs1 only when funct3 bit 2 is 0.
- R10: For a CSR access, csr_wr is set whenever funct3 bits 1:0 are 01. Otherwise it is set only when the rs1/immediate field (bits 19:15) is nonzero.
- R11: LUI (0110111) and AUIPC (0010111) write rd. OP-IMM (0010011) and OP-IMM-32 (0011011, funct3 000/001/101) read rs1 and write rd. OP (0110011) and OP-32 (0111011) with funct7 0000000 or 0100000 read rs1 and rs2 and write rd. All of these have class 0 (simple).
- R12: Every instruction other than a jump or a conditional branch reports one candidate, npc_a = PC+4 (modulo 2^64), with npc_b zero and the indirect flag clear.
- R13: Any other word gives empty masks, csr_rd and csr_wr clear, CSR number zero, class 0, and the sequential candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and PC are valid this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 64 | Address of the instruction |
| out_valid | output | 1 | Results belong to the word presented one cycle earlier |
| out_rd_mask | output | 32 | General registers read |
| out_wr_mask | output | 32 | General registers written |
| out_addr_mask | output | 32 | General registers forming a memory address |
| out_csr_rd | output | 1 | A CSR is read |
| out_csr_wr | output | 1 | A CSR is written |
| out_csr_num | output | 12 | CSR number, zero if no CSR access |
| out_kind | output | 3 | Class: 0 simple, 1 branch, 2 memory read, 3 memory write, 4 read-modify-write |
| out_npc_count | output | 2 | Number of next-PC candidates (1 or 2) |
| out_npc_a | output | 64 | First candidate (target, or PC+4 when sequential) |
| out_npc_b | output | 64 | Second candidate (PC+4 of a conditional branch), else zero |
| out_npc_indirect | output | 1 | The single candidate is unknown (register-indirect jump) |

## Verification
The hardest cases to reach sit where a recognised opcode meets a neighbouring field value that changes the result. Examples are a load-reserved with a nonzero rs2 field, a CSR set or clear whose source field is zero, and an atomic funct5 outside the listed set. Directed words place each of these next to its recognised twin. A long random run then forces the opcode to each group while leaving every other bit random, and drops the valid strobe often so that the held results are compared while the inputs keep changing.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    typedef enum logic [2:0] {
        K_SIMPLE = 3'd0,
        K_BRANCH = 3'd1,
        K_LOAD   = 3'd2,
        K_STORE  = 3'd3,
        K_RMW    = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        FL_SEQ   = 2'd0,
        FL_JUMP  = 2'd1,
        FL_INDIR = 2'd2,
        FL_COND  = 2'd3
    } flow_e;

    typedef struct packed {
        logic        use_rs1;
        logic        use_rs2;
        logic        use_rd;
        logic        addr_rs1;
        logic        csr_rd;
        logic        csr_wr;
        logic [11:0] csr_num;
        kind_e       kind;
        flow_e       flow;
    } dec_t;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OPIMMW = 7'b0011011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_OPW    = 7'b0111011;
    localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

endpackage

// File: rtl/rfp_op_decode.sv
module rfp_op_decode
    import rfp_pkg::*;
(
    input  logic [6:0]  opc,
    input  logic [2:0]  fn3,
    input  logic [31:15] hi,
    output dec_t        dec
);
    logic [6:0] fn7;
    logic [4:0] fn5;
    logic [4:0] rs1_f;
    logic [4:0] rs2_f;

    assign fn7   = hi[31:25];
    assign fn5   = hi[31:27];
    assign rs2_f = hi[24:20];
    assign rs1_f = hi[19:15];

    always_comb begin
        dec      = '0;
        dec.kind = K_SIMPLE;
        dec.flow = FL_SEQ;
        case (opc)
            OPC_LUI, OPC_AUIPC: dec.use_rd = 1'b1;
            OPC_JAL: begin
                dec.use_rd = 1'b1;
                dec.kind   = K_BRANCH;
                dec.flow   = FL_JUMP;
            end
            OPC_JALR: if (fn3 == 3'b000) begin
                dec.use_rs1 = 1'b1;
                dec.use_rd  = 1'b1;
                dec.kind    = K_BRANCH;
                dec.flow    = FL_INDIR;
            end
            OPC_BRANCH: if (fn3[2:1] != 2'b01) begin
                dec.use_rs1 = 1'b1;
                dec.use_rs2 = 1'b1;
                dec.kind    = K_BRANCH;
                dec.flow    = FL_COND;
            end
            OPC_LOAD: if (fn3 != 3'b111) begin
                dec.use_rs1  = 1'b1;
                dec.addr_rs1 = 1'b1;
                dec.use_rd   = 1'b1;
                dec.kind     = K_LOAD;
            end
            OPC_STORE: if (!fn3[2]) begin
                dec.use_rs1  = 1'b1;
                dec.use_rs2  = 1'b1;
                dec.addr_rs1 = 1'b1;
                dec.kind     = K_STORE;
            end
            OPC_OPIMM: begin
                dec.use_rs1 = 1'b1;
                dec.use_rd  = 1'b1;
            end
            OPC_OPIMMW: if (fn3 == 3'b000 || fn3 == 3'b001 || fn3 == 3'b101) begin
                dec.use_rs1 = 1'b1;
                dec.use_rd  = 1'b1;
            end
            OPC_OP, OPC_OPW: if (fn7 == 7'b0000000 || fn7 == 7'b0100000) begin
                dec.use_rs1 = 1'b1;
                dec.use_rs2 = 1'b1;
                dec.use_rd  = 1'b1;
            end
            OPC_ATOMIC: if (fn3[2:1] == 2'b01) begin
                case (fn5)
                    5'b00010: if (rs2_f == 5'd0) begin
                        dec.use_rs1  = 1'b1;
                        dec.addr_rs1 = 1'b1;
                        dec.use_rd   = 1'b1;
                        dec.kind     = K_LOAD;
                    end
                    5'b00011: begin
                        dec.use_rs1  = 1'b1;
                        dec.use_rs2  = 1'b1;
                        dec.addr_rs1 = 1'b1;
                        dec.use_rd   = 1'b1;
                        dec.kind     = K_STORE;
                    end
                    5'b00000, 5'b00001, 5'b00100, 5'b01000, 5'b01100,
                    5'b10000, 5'b10100, 5'b11000, 5'b11100: begin
                        dec.use_rs1  = 1'b1;
                        dec.use_rs2  = 1'b1;
                        dec.addr_rs1 = 1'b1;
                        dec.use_rd   = 1'b1;
                        dec.kind     = K_RMW;
                    end
                    default: ;
                endcase
            end
            OPC_SYSTEM: if (fn3[1:0] != 2'b00) begin
                dec.csr_rd  = 1'b1;
                dec.csr_num = hi[31:20];
                dec.use_rd  = 1'b1;
                dec.use_rs1 = !fn3[2];
                dec.csr_wr  = (fn3[1:0] == 2'b01) || (rs1_f != 5'd0);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rfp_reg_mask.sv
module rfp_reg_mask #(
    parameter int unsigned NREG = 32,
    localparam int unsigned IDXW = $clog2(NREG)
) (
    input  logic [IDXW-1:0] idx,
    input  logic            en,
    output logic [NREG-1:0] mask
);
    assign mask[0] = 1'b0;
    for (genvar gi = 1; gi < NREG; gi++) begin : g_bit
        assign mask[gi] = en && (idx == IDXW'(gi));
    end
endmodule

// File: rtl/rfp_target_gen.sv
module rfp_target_gen
    import rfp_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [31:7]     instr,
    input  logic [XLEN-1:0] pc,
    input  flow_e           flow,
    output logic [1:0]      cnt,
    output logic [XLEN-1:0] tgt_a,
    output logic [XLEN-1:0] tgt_b,
    output logic            indir
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] imm_j;
    logic [XLEN-1:0] imm_b;
    logic [XLEN-1:0] seq_pc;

    assign imm_j  = {{(XLEN-20){instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
    assign imm_b  = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};
    assign seq_pc = pc + STEP;

    always_comb begin
        cnt   = 2'd1;
        tgt_a = seq_pc;
        tgt_b = '0;
        indir = 1'b0;
        case (flow)
            FL_JUMP:  tgt_a = pc + imm_j;
            FL_INDIR: begin
                tgt_a = '0;
                indir = 1'b1;
            end
            FL_COND: begin
                cnt   = 2'd2;
                tgt_a = pc + imm_b;
                tgt_b = seq_pc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/reg_footprint_unit.sv
module reg_footprint_unit
    import rfp_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_pc,
    output logic            out_valid,
    output logic [NREG-1:0] out_rd_mask,
    output logic [NREG-1:0] out_wr_mask,
    output logic [NREG-1:0] out_addr_mask,
    output logic            out_csr_rd,
    output logic            out_csr_wr,
    output logic [11:0]     out_csr_num,
    output logic [2:0]      out_kind,
    output logic [1:0]      out_npc_count,
    output logic [XLEN-1:0] out_npc_a,
    output logic [XLEN-1:0] out_npc_b,
    output logic            out_npc_indirect
);
    localparam int unsigned IDXW = $clog2(NREG);

    typedef struct packed {
        logic            vld;
        logic [NREG-1:0] rmask;
        logic [NREG-1:0] wmask;
        logic [NREG-1:0] amask;
        logic            csr_rd;
        logic            csr_wr;
        logic [11:0]     csr_num;
        kind_e           kind;
        logic [1:0]      cnt;
        logic [XLEN-1:0] tgt_a;
        logic [XLEN-1:0] tgt_b;
        logic            indir;
    } res_t;

    res_t res_d, res_q;
    dec_t dec;

    logic [NREG-1:0] m_rs1, m_rs2, m_rd;
    logic [1:0]      t_cnt;
    logic [XLEN-1:0] t_a, t_b;
    logic            t_ind;

    rfp_op_decode u_dec (
        .opc (in_instr[6:0]),
        .fn3 (in_instr[14:12]),
        .hi  (in_instr[31:15]),
        .dec (dec)
    );

    rfp_reg_mask #(.NREG(NREG)) u_m_rs1 (
        .idx (in_instr[15 +: IDXW]), .en (dec.use_rs1), .mask (m_rs1)
    );
    rfp_reg_mask #(.NREG(NREG)) u_m_rs2 (
        .idx (in_instr[20 +: IDXW]), .en (dec.use_rs2), .mask (m_rs2)
    );
    rfp_reg_mask #(.NREG(NREG)) u_m_rd (
        .idx (in_instr[7 +: IDXW]), .en (dec.use_rd), .mask (m_rd)
    );

    rfp_target_gen #(.XLEN(XLEN)) u_tgt (
        .instr (in_instr[31:7]),
        .pc    (in_pc),
        .flow  (dec.flow),
        .cnt   (t_cnt),
        .tgt_a (t_a),
        .tgt_b (t_b),
        .indir (t_ind)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid;
        if (in_valid) begin
            res_d.rmask   = m_rs1 | m_rs2;
            res_d.wmask   = m_rd;
            res_d.amask   = dec.addr_rs1 ? m_rs1 : '0;
            res_d.csr_rd  = dec.csr_rd;
            res_d.csr_wr  = dec.csr_wr;
            res_d.csr_num = dec.csr_num;
            res_d.kind    = dec.kind;
            res_d.cnt     = t_cnt;
            res_d.tgt_a   = t_a;
            res_d.tgt_b   = t_b;
            res_d.indir   = t_ind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid        = res_q.vld;
    assign out_rd_mask      = res_q.rmask;
    assign out_wr_mask      = res_q.wmask;
    assign out_addr_mask    = res_q.amask;
    assign out_csr_rd       = res_q.csr_rd;
    assign out_csr_wr       = res_q.csr_wr;
    assign out_csr_num      = res_q.csr_num;
    assign out_kind         = res_q.kind;
    assign out_npc_count    = res_q.cnt;
    assign out_npc_a        = res_q.tgt_a;
    assign out_npc_b        = res_q.tgt_b;
    assign out_npc_indirect = res_q.indir;
endmodule

// File: rtl/rfp_checker.sv
module rfp_checker #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned NREG = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic [NREG-1:0] out_rd_mask,
    input logic [NREG-1:0] out_wr_mask,
    input logic [NREG-1:0] out_addr_mask,
    input logic            out_csr_rd,
    input logic            out_csr_wr,
    input logic [2:0]      out_kind,
    input logic [1:0]      out_npc_count,
    input logic [XLEN-1:0] out_npc_a,
    input logic            out_npc_indirect
);
    // R1
    x0_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rd_mask[0] && !out_wr_mask[0] && !out_addr_mask[0]);

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |->
        ($stable(out_rd_mask) && $stable(out_wr_mask) && $stable(out_addr_mask)
         && $stable(out_kind) && $stable(out_npc_a)));

    // R3
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 3'd2) |-> (out_addr_mask == out_rd_mask));

    // R4
    addr_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_addr_mask & ~out_rd_mask) == '0) && ($countones(out_addr_mask) <= 1));

    // R7
    indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_npc_indirect |-> (out_kind == 3'd1 && out_npc_count == 2'd1 && out_npc_a == '0));

    // R8
    two_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_npc_count == 2'd2) |-> (out_kind == 3'd1 && !out_npc_indirect));

    // R10
    csr_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_csr_wr |-> out_csr_rd);
endmodule

bind reg_footprint_unit rfp_checker #(.XLEN(XLEN), .NREG(NREG)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .out_valid        (out_valid),
    .out_rd_mask      (out_rd_mask),
    .out_wr_mask      (out_wr_mask),
    .out_addr_mask    (out_addr_mask),
    .out_csr_rd       (out_csr_rd),
    .out_csr_wr       (out_csr_wr),
    .out_kind         (out_kind),
    .out_npc_count    (out_npc_count),
    .out_npc_a        (out_npc_a),
    .out_npc_indirect (out_npc_indirect)
);

// File: tb/reg_footprint_unit_bench.sv
`timescale 1ns/1ps
module reg_footprint_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [63:0] in_pc = '0;
    logic        out_valid;
    logic [31:0] out_rd_mask, out_wr_mask, out_addr_mask;
    logic        out_csr_rd, out_csr_wr;
    logic [11:0] out_csr_num;
    logic [2:0]  out_kind;
    logic [1:0]  out_npc_count;
    logic [63:0] out_npc_a, out_npc_b;
    logic        out_npc_indirect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    reg_footprint_unit u_reg_footprint_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr), .in_pc(in_pc),
        .out_valid(out_valid), .out_rd_mask(out_rd_mask), .out_wr_mask(out_wr_mask),
        .out_addr_mask(out_addr_mask), .out_csr_rd(out_csr_rd), .out_csr_wr(out_csr_wr),
        .out_csr_num(out_csr_num), .out_kind(out_kind), .out_npc_count(out_npc_count),
        .out_npc_a(out_npc_a), .out_npc_b(out_npc_b), .out_npc_indirect(out_npc_indirect)
    );

    typedef struct {
        bit          vld;
        bit [31:0]   rm, wm, am;
        bit          crd, cwr;
        bit [11:0]   cnum;
        int          kind;
        int          cnt;
        bit [63:0]   a, b;
        bit          ind;
    } exp_t;

    exp_t  pend;
    string pend_tag = "R2";

    function automatic exp_t ref_of(input bit [31:0] w, input bit [63:0] pc);
        exp_t e;
        int op = int'(w[6:0]);
        int f3 = int'(w[14:12]);
        int f7 = int'(w[31:25]);
        int f5 = int'(w[31:27]);
        int rd = int'(w[11:7]);
        int r1 = int'(w[19:15]);
        int r2 = int'(w[24:20]);
        bit u1 = 0, u2 = 0, ud = 0, ad = 0;
        int flow = 0;
        longint off;
        e = '{default: 0};
        e.vld = 1;
        case (op)
            'h37, 'h17: ud = 1;
            'h6f: begin ud = 1; flow = 1; e.kind = 1; end
            'h67: if (f3 == 0) begin u1 = 1; ud = 1; flow = 2; e.kind = 1; end
            'h63: if (f3 != 2 && f3 != 3) begin u1 = 1; u2 = 1; flow = 3; e.kind = 1; end
            'h03: if (f3 != 7) begin u1 = 1; ud = 1; ad = 1; e.kind = 2; end
            'h23: if (f3 < 4) begin u1 = 1; u2 = 1; ad = 1; e.kind = 3; end
            'h13: begin u1 = 1; ud = 1; end
            'h1b: if (f3 == 0 || f3 == 1 || f3 == 5) begin u1 = 1; ud = 1; end
            'h33, 'h3b: if (f7 == 0 || f7 == 32) begin u1 = 1; u2 = 1; ud = 1; end
            'h2f: if (f3 == 2 || f3 == 3) begin
                if (f5 == 2) begin
                    if (r2 == 0) begin u1 = 1; ud = 1; ad = 1; e.kind = 2; end
                end else if (f5 == 3) begin
                    u1 = 1; u2 = 1; ud = 1; ad = 1; e.kind = 3;
                end else if (f5 == 0 || f5 == 1 || (f5 % 4 == 0)) begin
                    u1 = 1; u2 = 1; ud = 1; ad = 1; e.kind = 4;
                end
            end
            'h73: if (f3 != 0 && f3 != 4) begin
                e.crd = 1; e.cnum = w[31:20]; ud = 1;
                u1 = (f3 < 4);
                e.cwr = ((f3 % 4) == 1) || (r1 != 0);
            end
            default: ;
        endcase
        for (int i = 1; i < 32; i++) begin
            if ((u1 && r1 == i) || (u2 && r2 == i)) e.rm[i] = 1;
            if (ud && rd == i) e.wm[i] = 1;
            if (ad && r1 == i) e.am[i] = 1;
        end
        e.cnt = 1;
        e.a = pc + 64'd4;
        if (flow == 1) begin
            off = longint'(w[19:12]) * 4096 + longint'(w[20]) * 2048 + longint'(w[30:21]) * 2;
            if (w[31]) off = off - 1048576;
            e.a = pc + 64'(off);
        end else if (flow == 2) begin
            e.a = 0; e.ind = 1;
        end else if (flow == 3) begin
            off = longint'(w[7]) * 2048 + longint'(w[30:25]) * 32 + longint'(w[11:8]) * 2;
            if (w[31]) off = off - 4096;
            e.cnt = 2; e.a = pc + 64'(off); e.b = pc + 64'd4;
        end
        return e;
    endfunction

    function automatic string tag_of(input bit [31:0] w);
        exp_t e = ref_of(w, 64'd0);
        if (e.crd) return "R9";
        if (w[6:0] == 7'h6f) return "R6";
        if (w[6:0] == 7'h67 && e.ind) return "R7";
        if (e.cnt == 2) return "R8";
        if (e.kind == 2) return "R3";
        if (e.kind == 3 && w[6:0] == 7'h23) return "R4";
        if (e.kind == 3 || e.kind == 4) return "R5";
        if (e.wm != 0 || e.rm != 0 || w[11:7] == 5'd0) begin
            if (w[6:0] inside {7'h37, 7'h17, 7'h13, 7'h1b, 7'h33, 7'h3b}) begin
                if (ref_of(w | 32'h80, 64'd0).wm != 0) return "R11";
            end
        end
        return "R13";
    endfunction

    task automatic chk(input string tag, input string what, input bit [63:0] act, input bit [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        string tn = (pend.cnt == 1 && pend.a == 0 && !pend.ind) ? pend_tag :
                    ((pend_tag == "R6" || pend_tag == "R7" || pend_tag == "R8" || pend_tag == "R2") ? pend_tag : "R12");
        string tc = (pend_tag == "R9") ? "R10" : pend_tag;
        chk("R2", "valid", 64'(out_valid), 64'(pend.vld));
        chk("R1", "x0 bits", 64'({out_rd_mask[0], out_wr_mask[0], out_addr_mask[0]}), 64'd0);
        chk(pend_tag, "read mask", 64'(out_rd_mask), 64'(pend.rm));
        chk(pend_tag, "write mask", 64'(out_wr_mask), 64'(pend.wm));
        chk(pend_tag, "addr mask", 64'(out_addr_mask), 64'(pend.am));
        chk(pend_tag, "csr read", 64'(out_csr_rd), 64'(pend.crd));
        chk(tc, "csr write", 64'(out_csr_wr), 64'(pend.cwr));
        chk(pend_tag, "csr num", 64'(out_csr_num), 64'(pend.cnum));
        chk(pend_tag, "kind", 64'(out_kind), 64'(pend.kind));
        chk(tn, "npc count", 64'(out_npc_count), 64'(pend.cnt));
        chk(tn, "npc a", out_npc_a, pend.a);
        chk(tn, "npc b", out_npc_b, pend.b);
        chk(tn, "indirect", 64'(out_npc_indirect), 64'(pend.ind));
    endtask

    task automatic step(input bit v, input bit [31:0] w, input bit [63:0] pc);
        @(negedge clk);
        compare();
        in_valid = v;
        in_instr = w;
        in_pc    = pc;
        if (v) begin
            pend     = ref_of(w, pc);
            pend_tag = tag_of(w);
        end else begin
            pend.vld = 0;
            pend_tag = "R2";
        end
    endtask

    function automatic bit [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd, bit [6:0] op);
        return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), op};
    endfunction
    function automatic bit [31:0] enc_i(int imm, int rs1, int f3, int rd, bit [6:0] op);
        return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), op};
    endfunction
    function automatic bit [31:0] enc_b(int off, int rs2, int rs1, int f3);
        bit [12:0] o = 13'(off);
        return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'(f3), o[4:1], o[11], 7'h63};
    endfunction
    function automatic bit [31:0] enc_j(int off, int rd);
        bit [20:0] o = 21'(off);
        return {o[20], o[10:1], o[11], o[19:12], 5'(rd), 7'h6f};
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        pend = '{default: 0};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R2), then directed words
        step(1, enc_i(12'h010, 5, 3, 7, 7'h03), 64'h1000);          // R3 ld
        step(1, enc_i(0, 0, 2, 0, 7'h03), 64'h1004);                // R1 x0 operands
        step(1, enc_r(7'h08, 0, 9, 3, 4, 7'h2f), 64'h1008);         // R3 lr
        step(1, enc_r(7'h08, 6, 9, 3, 4, 7'h2f), 64'h100c);         // R13 lr with rs2 != 0
        step(1, {7'h01, 5'd12, 5'd13, 3'd3, 5'h08, 7'h23}, 64'h1010); // R4 sd
        step(1, enc_r(7'h0c, 14, 15, 2, 16, 7'h2f), 64'h1014);      // R5 sc
        step(1, enc_r(7'h06, 14, 15, 2, 16, 7'h2f), 64'h1018);      // R5 amo rmw
        step(1, enc_r(7'h14, 14, 15, 2, 16, 7'h2f), 64'h101c);      // R13 bad funct5
        step(1, enc_j(-8, 1), 64'h2000);                            // R6 back jump
        step(1, enc_j(2046, 0), 64'h2000);                          // R6 rd x0
        step(1, enc_i(4, 1, 0, 5, 7'h67), 64'h3000);                // R7
        step(1, enc_b(-4096, 2, 3, 0), 64'h5000);                   // R8
        step(1, enc_b(4094, 2, 3, 7), 64'hffff_ffff_ffff_fffc);     // R8 wrap
        step(1, enc_i(12'h300, 0, 2, 5, 7'h73), 64'h4000);          // R10 csrrs rs1=x0
        step(1, enc_i(12'h341, 0, 1, 5, 7'h73), 64'h4004);          // R10 csrrw rs1=x0
        step(1, enc_i(12'h7c0, 0, 6, 5, 7'h73), 64'h4008);          // R10 csrrsi uimm 0
        step(1, enc_i(12'h7c0, 5, 7, 5, 7'h73), 64'h400c);          // R9 csrrci uimm 5
        step(1, enc_i(0, 0, 0, 0, 7'h73), 64'h4010);                // R13 ecall
        step(1, {20'h12345, 5'd3, 7'h37}, 64'hffff_ffff_ffff_fffc); // R11 R12 wrap
        step(1, enc_r(7'h20, 4, 5, 0, 6, 7'h3b), 64'h4018);         // R11
        step(1, enc_r(7'h01, 4, 5, 0, 6, 7'h33), 64'h401c);         // R13 funct7
        step(1, 32'h0ff0000f, 64'h4020);                            // R13 fence
        for (int i = 0; i < 6; i++) step(0, $urandom, {$urandom, $urandom}); // R2 hold
        for (int n = 0; n < 6000; n++) begin
            bit [31:0] w = $urandom;
            bit [6:0] ops[13] = '{7'h37, 7'h17, 7'h6f, 7'h67, 7'h63, 7'h03, 7'h23,
                                  7'h13, 7'h1b, 7'h33, 7'h3b, 7'h2f, 7'h73};
            int k = int'($urandom % 15);
            if (k < 13) w[6:0] = ops[k];
            if (w[6:0] == 7'h2f && $urandom % 2 == 1) w[14:12] = 3'd2;
            if ((w[6:0] == 7'h33 || w[6:0] == 7'h3b) && $urandom % 2 == 1) w[31:25] = 7'h00;
            step(($urandom % 4) != 0, w, {$urandom, $urandom} & ~64'h3);
        end
        step(0, 0, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule